// File: doc/BRIEF.md
# Per-Channel Cell Timestamp Inserter

This block sits on both cell paths of a switch port, the receive path and the transmit path. It carries byte-serial 53-byte cells with a 5-byte header and a 48-byte payload. It keeps a free-running 16-bit time count that advances once for each pulse of the switch-fabric frame strobe. For cells on selected channels, it overwrites two payload bytes with that count: on the receive path this records the arrival time, and on the transmit path it records the departure time. Every other byte passes through unchanged.

A table of enable bits, indexed by the low bits of the channel identifier (VCI), decides which channels are stamped. A 4-bit field of the VCI itself selects a 4-byte slot inside the payload. Different switches can therefore be set up to place their stamps at different points in the same cell. Inside the chosen slot, the arrival stamp takes the first two bytes and the departure stamp takes the next two. Both paths have the same fixed latency, whether or not a cell is stamped.

Top module: `cell_stamp_inserter`

## Requirements
- R1: The time count is zero after reset. It increments by one on every clock in which `frame_tick` is high, and wraps from 0xFFFF to 0x0000. A cell's stamp is the count held in the cycle of the cell's first byte, before any increment caused by that same cycle's tick.
- R2: On each path, `*_out_vld` and `*_out_sop` repeat `*_in_vld` and `*_in_sop` exactly one clock later. Both outputs are low after reset.
- R3: The enable table has `NUM_CH` one-bit entries, all zero after reset. Entry `VCI mod NUM_CH` governs a cell. A write (`cfg_we`, `cfg_chan`, `cfg_en`) affects lookups from the following clock onward. A cell's lookup is taken at its header byte 4, so a write in that same cycle does not affect that cell.
- R4: A receive cell on an enabled channel has the stamp written high byte first at cell bytes 5+4k and 6+4k, where k is the slot selector.
- R5: A transmit cell on an enabled channel has the stamp written high byte first at cell bytes 7+4k and 8+4k.
- R6: The slot selector is VCI bits [15:12]. Selector values 12 to 15 are clamped to 11, so they use payload bytes 44 to 47.
- R7: Cells on disabled channels leave the block with every byte unchanged, with the same one-clock latency.
- R8: The VCI is read from the header as follows: bits [15:12] from the low nibble of byte 1, bits [11:4] from byte 2, and bits [3:0] from the high nibble of byte 3. Header bytes are never altered.
- R9: The two paths are independent. Cells may start on both paths in the same cycle, and that cycle may also carry a frame tick.
- R10: Idle cycles (`*_in_vld` low) may appear inside a cell. Byte positions count only valid bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-clock pulse per fabric frame; advances the time count |
| cfg_we | input | 1 | Enable-table write strobe |
| cfg_chan | input | CH_W | Table entry to write |
| cfg_en | input | 1 | Value written: 1 = stamp this channel |
| rx_in_vld | input | 1 | Receive byte valid |
| rx_in_sop | input | 1 | Receive byte is cell byte 0 |
| rx_in_byte | input | 8 | Receive cell byte |
| rx_out_vld | output | 1 | Receive output valid |
| rx_out_sop | output | 1 | Receive output is cell byte 0 |
| rx_out_byte | output | 8 | Receive output byte (arrival stamp inserted) |
| tx_in_vld | input | 1 | Transmit byte valid |
| tx_in_sop | input | 1 | Transmit byte is cell byte 0 |
| tx_in_byte | input | 8 | Transmit cell byte |
| tx_out_vld | output | 1 | Transmit output valid |
| tx_out_sop | output | 1 | Transmit output is cell byte 0 |
| tx_out_byte | output | 8 | Transmit output byte (departure stamp inserted) |

## Verification
Stamp capture and counter advance can fall in the same cycle, on one path or on both paths at once. The bench provokes this by pulsing `frame_tick` in the very cycle that starts a receive cell and a transmit cell together. Both cells must then carry the pre-increment count, and the next cell must show the count one higher. A second collision, a table write landing on the lookup byte of a cell, is provoked the same way. It is judged by whether that cell and the following one are stamped.

// File: rtl/cstamp_pkg.sv
// Shared constants and helpers for the cell timestamp inserter.
// Assumes 53-byte cells: a 5-byte header and a 48-byte payload.
package cstamp_pkg;
    localparam int HDR_BYTES     = 5;
    localparam int PAYLOAD_BYTES = 48;
    localparam int CELL_BYTES    = HDR_BYTES + PAYLOAD_BYTES;
    localparam int STAMP_BYTES   = 2;
    localparam int TS_W          = STAMP_BYTES * 8;
    localparam int SLOT_BYTES    = 2 * STAMP_BYTES;
    localparam int NUM_SLOTS     = PAYLOAD_BYTES / SLOT_BYTES;
    localparam int SEL_W         = $clog2(NUM_SLOTS);
    localparam int POS_W         = $clog2(CELL_BYTES + 1);
    localparam int VCI_W         = 16;

    typedef logic [POS_W-1:0] pos_t;

    // Cell byte index of a lane's high stamp byte for a given slot selector,
    // with selectors beyond the last slot clamped to it.
    function automatic pos_t slot_pos(input logic [SEL_W-1:0] sel, input int lane);
        int k;
        k = (int'(sel) > NUM_SLOTS - 1) ? NUM_SLOTS - 1 : int'(sel);
        return pos_t'(HDR_BYTES + k * SLOT_BYTES + lane * STAMP_BYTES);
    endfunction
endpackage

// File: rtl/ts_counter.sv
// Free-running time count. Advances once per frame strobe and wraps silently.
// Assumes frame_tick is synchronous to clk and lasts one cycle per frame.
module ts_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] now
);
    // Count frame strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)    now <= '0;
        else if (tick) now <= now + W'(1);
    end

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> now == $past(now) + W'(1));
    p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(now));
endmodule

// File: rtl/chan_enable_table.sv
// Per-channel stamp enable bits, one write port and NUM_RD read ports.
// A channel maps to the entry given by its low index bits. Reads return the
// stored value, so a write becomes visible on the following cycle.
module chan_enable_table #(
    parameter int NUM_CH = 64,
    parameter int NUM_RD = 2,
    parameter int VCI_W  = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CH_W-1:0]              wr_chan,
    input  logic                         wr_val,
    input  logic [NUM_RD-1:0][VCI_W-1:0] rd_vci,
    output logic [NUM_RD-1:0]            rd_en
);
    logic [NUM_CH-1:0] en_q;

    // Store enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q[wr_chan] <= wr_val;
    end

    // One read port per lane.
    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        assign rd_en[g] = en_q[rd_vci[g][CH_W-1:0]];
    end

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> en_q[$past(wr_chan)] == $past(wr_val));
endmodule

// File: rtl/stamp_lane.sv
// One cell stream. It tracks the byte position, captures the VCI and the time
// at cell start, looks up the enable bit at header byte 4, and overwrites two
// payload bytes. It has a fixed one-cycle latency. LANE 0 is arrival, LANE 1
// is departure. It assumes sop marks byte 0 and that valid may have gaps.
module stamp_lane
    import cstamp_pkg::*;
#(
    parameter int LANE    = 0,
    parameter int OFS_LSB = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  now,
    input  logic             in_vld,
    input  logic             in_sop,
    input  logic [7:0]       in_byte,
    output logic [VCI_W-1:0] lk_vci,
    input  logic             lk_en,
    output logic             out_vld,
    output logic             out_sop,
    output logic [7:0]       out_byte
);
    pos_t             pos_q, cur_pos, ofs_q;
    logic [VCI_W-1:0] vci_q;
    logic [TS_W-1:0]  stamp_q;
    logic             hit_q, hi_sel, lo_sel;

    assign cur_pos = in_sop ? pos_t'(0) : pos_q;
    assign lk_vci  = vci_q;
    assign hi_sel  = hit_q && (cur_pos == ofs_q);
    assign lo_sel  = hit_q && (cur_pos == ofs_q + pos_t'(1));

    // Count valid bytes within the cell, saturating past the end.
    always_ff @(posedge clk) begin
        if (!rst_n)                pos_q <= '0;
        else if (in_vld && in_sop) pos_q <= pos_t'(1);
        else if (in_vld && pos_q != pos_t'(CELL_BYTES)) pos_q <= pos_q + pos_t'(1);
    end

    // Capture the time and VCI, then latch the stamp decision at byte 4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vci_q   <= '0;
            stamp_q <= '0;
            hit_q   <= 1'b0;
            ofs_q   <= '0;
        end else if (in_vld) begin
            if (in_sop) begin
                stamp_q <= now;
                hit_q   <= 1'b0;
            end
            case (cur_pos)
                pos_t'(1): vci_q[15:12] <= in_byte[3:0];
                pos_t'(2): vci_q[11:4]  <= in_byte;
                pos_t'(3): vci_q[3:0]   <= in_byte[7:4];
                pos_t'(HDR_BYTES-1): begin
                    hit_q <= lk_en;
                    ofs_q <= slot_pos(vci_q[OFS_LSB +: SEL_W], LANE);
                end
                default: ;
            endcase
        end
    end

    // Register the output with the stamp substituted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_sop  <= 1'b0;
            out_byte <= '0;
        end else begin
            out_vld  <= in_vld;
            out_sop  <= in_vld && in_sop;
            out_byte <= hi_sel ? stamp_q[15:8] : (lo_sel ? stamp_q[7:0] : in_byte);
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == $past(in_vld) && out_sop == $past(in_vld && in_sop));
    p_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !hit_q) |=> out_byte == $past(in_byte));
    p_header_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && cur_pos < pos_t'(HDR_BYTES)) |=> out_byte == $past(in_byte));
    p_slot_in_payload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> (ofs_q >= pos_t'(HDR_BYTES) && ofs_q + pos_t'(1) < pos_t'(CELL_BYTES)));
endmodule

// File: rtl/cell_stamp_inserter.sv
// Top level. It shares one time count and one enable table between the
// arrival (receive) lane and the departure (transmit) lane.
module cell_stamp_inserter
    import cstamp_pkg::*;
#(
    parameter int NUM_CH  = 64,
    parameter int OFS_LSB = 12,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_tick,
    input  logic            cfg_we,
    input  logic [CH_W-1:0] cfg_chan,
    input  logic            cfg_en,
    input  logic            rx_in_vld,
    input  logic            rx_in_sop,
    input  logic [7:0]      rx_in_byte,
    output logic            rx_out_vld,
    output logic            rx_out_sop,
    output logic [7:0]      rx_out_byte,
    input  logic            tx_in_vld,
    input  logic            tx_in_sop,
    input  logic [7:0]      tx_in_byte,
    output logic            tx_out_vld,
    output logic            tx_out_sop,
    output logic [7:0]      tx_out_byte
);
    localparam int NL = 2;

    logic [TS_W-1:0]           now;
    logic [NL-1:0][VCI_W-1:0]  lk_vci;
    logic [NL-1:0]             lk_en;
    logic [NL-1:0]             i_vld, i_sop, o_vld, o_sop;
    logic [NL-1:0][7:0]        i_byte, o_byte;

    assign i_vld  = {tx_in_vld,  rx_in_vld};
    assign i_sop  = {tx_in_sop,  rx_in_sop};
    assign i_byte = {tx_in_byte, rx_in_byte};
    assign {tx_out_vld,  rx_out_vld}  = o_vld;
    assign {tx_out_sop,  rx_out_sop}  = o_sop;
    assign {tx_out_byte, rx_out_byte} = o_byte;

    ts_counter #(.W(TS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(frame_tick), .now(now)
    );

    chan_enable_table #(.NUM_CH(NUM_CH), .NUM_RD(NL), .VCI_W(VCI_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_chan(cfg_chan),
        .wr_val(cfg_en), .rd_vci(lk_vci), .rd_en(lk_en)
    );

    // Lane 0 stamps arrivals, lane 1 stamps departures.
    for (genvar g = 0; g < NL; g++) begin : g_lane
        stamp_lane #(.LANE(g), .OFS_LSB(OFS_LSB)) u_lane (
            .clk(clk), .rst_n(rst_n), .now(now),
            .in_vld(i_vld[g]), .in_sop(i_sop[g]), .in_byte(i_byte[g]),
            .lk_vci(lk_vci[g]), .lk_en(lk_en[g]),
            .out_vld(o_vld[g]), .out_sop(o_sop[g]), .out_byte(o_byte[g])
        );
    end
endmodule

// File: tb/tb_cell_stamp_inserter.sv
module tb_cell_stamp_inserter;
    logic clk = 1'b0, rst_n = 1'b0, frame_tick = 1'b0;
    logic cfg_we = 1'b0, cfg_en = 1'b0;
    logic [5:0] cfg_chan = '0;
    logic rx_in_vld = 1'b0, rx_in_sop = 1'b0, tx_in_vld = 1'b0, tx_in_sop = 1'b0;
    logic [7:0] rx_in_byte = '0, tx_in_byte = '0;
    logic rx_out_vld, rx_out_sop, tx_out_vld, tx_out_sop;
    logic [7:0] rx_out_byte, tx_out_byte;

    int checks = 0, fails = 0;
    logic [15:0] cnt = '0;                 // bench model of the time count
    logic [7:0] cap [2][53];
    int ncap [2] = '{0, 0};
    bit done = 0;

    always #5 clk = ~clk;

    cell_stamp_inserter dut (.*);

    // Vector: {vci[15:0], is_tx, enable, expected high-stamp position (0 = none)}
    localparam logic [23:0] VEC [10] = '{
        {16'h0005, 1'b0, 1'b1, 6'd5},   // R4 k=0
        {16'h3009, 1'b0, 1'b1, 6'd17},  // R4 k=3
        {16'h300A, 1'b1, 1'b1, 6'd19},  // R5 k=3
        {16'hB00C, 1'b0, 1'b1, 6'd49},  // R4 last slot
        {16'hF00D, 1'b1, 1'b1, 6'd51},  // R6 clamp on tx
        {16'hC00E, 1'b0, 1'b1, 6'd49},  // R6 clamp on rx
        {16'h2010, 1'b0, 1'b0, 6'd0},   // R7 disabled rx
        {16'h7011, 1'b1, 1'b0, 6'd0},   // R7 disabled tx
        {16'h5041, 1'b1, 1'b1, 6'd27},  // R3 index by low bits, R5
        {16'hA018, 1'b0, 1'b1, 6'd45}   // R4 k=10
    };

    function automatic logic [7:0] cell_byte(input logic [15:0] v, input int b);
        case (b)
            0: return 8'h0C;
            1: return {4'h0, v[15:12]};
            2: return v[11:4];
            3: return {v[3:0], 4'h2};
            4: return 8'h5A;
            default: return 8'(b * 29 + 7) ^ v[7:0];
        endcase
    endfunction

    // Collect output bytes away from the clock edge.
    always @(negedge clk) begin
        if (rx_out_vld) begin
            if (rx_out_sop) ncap[0] = 0;
            if (ncap[0] < 53) cap[0][ncap[0]] = rx_out_byte;
            ncap[0]++;
        end
        if (tx_out_vld) begin
            if (tx_out_sop) ncap[1] = 0;
            if (ncap[1] < 53) cap[1][ncap[1]] = tx_out_byte;
            ncap[1]++;
        end
    end

    task automatic cfg_write(input logic [5:0] ch, input logic en);
        @(negedge clk); cfg_we = 1'b1; cfg_chan = ch; cfg_en = en;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); frame_tick = 1'b1; end
        @(negedge clk); frame_tick = 1'b0;
        cnt = cnt + 16'(n);
    endtask

    task automatic send(input logic do_rx, input logic do_tx, input logic [15:0] vr,
                        input logic [15:0] vt, input logic gaps, input logic tick0,
                        input logic cfg4, input logic cfg4_en);
        for (int b = 0; b < 53; b++) begin
            @(negedge clk);
            rx_in_vld = do_rx; rx_in_sop = do_rx && b == 0; rx_in_byte = cell_byte(vr, b);
            tx_in_vld = do_tx; tx_in_sop = do_tx && b == 0; tx_in_byte = cell_byte(vt, b);
            frame_tick = tick0 && b == 0;
            cfg_we = cfg4 && b == 4; cfg_chan = vr[5:0]; cfg_en = cfg4_en;
            if (gaps) begin
                @(negedge clk);
                rx_in_vld = 1'b0; rx_in_sop = 1'b0; tx_in_vld = 1'b0; tx_in_sop = 1'b0;
                frame_tick = 1'b0; cfg_we = 1'b0;
            end
        end
        @(negedge clk);
        rx_in_vld = 1'b0; rx_in_sop = 1'b0; tx_in_vld = 1'b0; tx_in_sop = 1'b0;
        frame_tick = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_lane(input int ln, input logic [15:0] v, input int pos,
                              input logic [15:0] st, input string req);
        int bad = -1;
        logic [7:0] e, a;
        checks++;
        for (int b = 0; b < 53; b++) begin
            e = cell_byte(v, b);
            if (pos != 0 && b == pos)     e = st[15:8];
            if (pos != 0 && b == pos + 1) e = st[7:0];
            if (bad < 0 && cap[ln][b] !== e) begin bad = b; a = cap[ln][b]; end
        end
        if (ncap[ln] != 53) begin
            fails++;
            $display("FAIL %s lane %0d: byte count %0d expected 53", req, ln, ncap[ln]);
        end else if (bad >= 0) begin
            fails++;
            $display("FAIL %s lane %0d vci %h byte %0d: got %h expected %h",
                     req, ln, v, bad, a, (bad == pos) ? st[15:8] :
                     (bad == pos + 1) ? st[7:0] : cell_byte(v, bad));
        end
    endtask

    initial begin
        logic [15:0] v, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state of outputs
        checks++;
        if (rx_out_vld !== 1'b0 || tx_out_vld !== 1'b0) begin
            fails++;
            $display("FAIL R2 reset: vld %b%b expected 00", rx_out_vld, tx_out_vld);
        end
        // R1: count is zero after reset
        cfg_write(6'h03, 1'b1);
        send(1, 0, 16'h2003, 16'h0, 0, 0, 0, 0);
        check_lane(0, 16'h2003, 13, 16'h0000, "R1 reset count");

        // Vector walk
        for (int i = 0; i < 10; i++) begin
            v = VEC[i][23:8];
            cfg_write(v[5:0], VEC[i][6]);
            ticks(i + 1);
            if (VEC[i][7]) send(0, 1, 16'h0, v, 0, 0, 0, 0);
            else           send(1, 0, v, 16'h0, 0, 0, 0, 0);
            check_lane(int'(VEC[i][7]), v, int'(VEC[i][5:0]), cnt, "R4/R5/R6/R7 vector");
        end

        // R9: both paths start together on a tick cycle
        cfg_write(6'h20, 1'b1);
        cfg_write(6'h21, 1'b1);
        s = cnt;
        send(1, 1, 16'h4020, 16'h1021, 0, 1, 0, 0);
        cnt = cnt + 16'd1;
        check_lane(0, 16'h4020, 21, s, "R9 rx same-cycle tick");
        check_lane(1, 16'h1021, 11, s, "R9 tx same-cycle tick");
        send(1, 0, 16'h4020, 16'h0, 0, 0, 0, 0);
        check_lane(0, 16'h4020, 21, cnt, "R1 tick at sop counted");

        // R10: idle cycles inside a cell
        cfg_write(6'h22, 1'b1);
        send(1, 1, 16'h6022, 16'h6022, 1, 0, 0, 0);
        check_lane(0, 16'h6022, 29, cnt, "R10 gaps rx");
        check_lane(1, 16'h6022, 31, cnt, "R10 gaps tx");

        // R3: write on the lookup byte affects only later cells
        send(1, 0, 16'h8023, 16'h0, 0, 0, 1, 1);
        check_lane(0, 16'h8023, 0, cnt, "R3 enable on lookup byte");
        send(1, 0, 16'h8023, 16'h0, 0, 0, 1, 0);
        check_lane(0, 16'h8023, 37, cnt, "R3 enabled next cell");
        send(1, 0, 16'h8023, 16'h0, 0, 0, 0, 0);
        check_lane(0, 16'h8023, 0, cnt, "R3 disabled next cell");

        // R3: aliasing by low VCI bits, R8 header decode
        send(0, 1, 16'h0061, 16'h0061, 0, 0, 0, 0);
        check_lane(1, 16'h0061, 7, cnt, "R3 alias / R8");

        // R1: wrap of the count
        ticks(int'(16'hFFFF - cnt));
        send(1, 0, 16'h2003, 16'h0, 0, 0, 0, 0);
        check_lane(0, 16'h2003, 13, 16'hFFFF, "R1 max count");
        ticks(1);
        send(1, 0, 16'h2003, 16'h0, 0, 0, 0, 0);
        check_lane(0, 16'h2003, 13, 16'h0000, "R1 wrap");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule